// File: doc/BRIEF.md
# Processor-Side Interrupt Acknowledge Interface

This block sits between an interrupt distributor and a single processor. The distributor forwards one candidate interrupt with its ID, priority and, for software interrupts, the number of the CPU that raised it. The interface decides whether the candidate may reach the processor and drives a level request line when it may. It also keeps a small record of the interrupts the processor is currently servicing.

Software uses a 32-bit register port. It reads an acknowledge register to claim the candidate. That read sends a one-cycle handshake to the distributor, so that the ID moves from pending to active. When the handler is done, software writes the same value back to an end-of-interrupt register. A valid end-of-interrupt write retires the entry and sends a one-cycle handshake to the distributor.

A candidate is forwarded only if all of the following hold: signalling is enabled, its priority value is below the mask, and its priority value is below the priority of every interrupt in service. Software keeps reading the acknowledge register until it receives the spurious code.

Top module: `cpu_intf_ack`

## Requirements
- R1: After reset, `irq_out` is low, the control and priority-mask registers read as 0, and an acknowledge read returns 1023 without a handshake.
- R2: Word address 0 is the control register, and its bit 0 enables signalling. While that bit is 0, `irq_out` stays low and acknowledge reads return 1023.
- R3: Word address 1 holds an 8-bit priority mask. A candidate qualifies only when its priority value is strictly below the mask, so a candidate equal to the mask is blocked.
- R4: Reading word address 2 returns the acknowledge value one cycle after the read, with the ID in bits [9:0] and the source CPU in bits [12:10]. The source field is filled only for IDs 0 to 15 and is 0 for all other IDs. Forwarded IDs never exceed 510.
- R5: A qualifying acknowledge read raises `ack_req` for exactly one cycle, in the same cycle as the read data, with `ack_id` and `ack_src` equal to the returned fields.
- R6: An acknowledge read returns 1023 and raises no handshake when no candidate is valid, when the candidate is blocked by the mask, or when it is not above the running priority.
- R7: Once an interrupt is acknowledged, its priority becomes the running priority. Only candidates with a strictly lower priority value raise `irq_out` after that, one cycle after they are presented.
- R8: Writing word address 3 with a value whose bits [12:0] equal an active entry raises `eoi_req` for one cycle on the next cycle, carrying that ID and source. The entry is removed, and the running priority falls back to the entry that is now on top.
- R9: A write to word address 3 that matches no active entry is ignored. It raises no `eoi_req` and leaves the running priority unchanged.
- R10: End-of-interrupt writes may arrive out of order. Retiring an entry below the top leaves the running priority at the top entry's value.
- R11: At most 4 interrupts (DEPTH) are active at once. When the record is full, `irq_out` stays low and acknowledge reads return 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the read |
| fwd_valid | input | 1 | The distributor presents a candidate |
| fwd_id | input | 10 | Candidate interrupt ID |
| fwd_src | input | 3 | Requesting CPU of a software interrupt |
| fwd_prio | input | 8 | Candidate priority, where a lower value is more urgent |
| ack_req | output | 1 | Acknowledge handshake to the distributor |
| ack_id | output | 10 | ID that was acknowledged |
| ack_src | output | 3 | Source that was acknowledged |
| eoi_req | output | 1 | End-of-interrupt handshake to the distributor |
| eoi_id | output | 10 | ID that was retired |
| eoi_src | output | 3 | Source that was retired |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the distributor never forwards an ID above 510. They also assume that a read and a write never fall in the same cycle, and that the distributor withdraws or replaces a candidate once it has been acknowledged. The bench keeps to these rules: it issues exactly one register access per task call, and it lowers `fwd_valid` or presents a new candidate after every acknowledge. Running-priority and depth effects are observed only through `irq_out`, the acknowledge value and the end-of-interrupt handshake.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_PMASK = 2'd1,
    RA_ACK   = 2'd2,
    RA_EOI   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cpuif_gate.sv
module cpuif_gate #(
  parameter int ID_W    = 10,
  parameter int SRC_W   = 3,
  parameter int PRIO_W  = 8,
  parameter int SGI_NUM = 16
) (
  input  logic              fwd_valid,
  input  logic [ID_W-1:0]   fwd_id,
  input  logic [SRC_W-1:0]  fwd_src,
  input  logic [PRIO_W-1:0] fwd_prio,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              full,
  output logic              cand_ok,
  output logic [SRC_W-1:0]  cand_src
);
  localparam logic [ID_W-1:0] SGI_LIM = ID_W'(SGI_NUM);

  always_comb begin
    cand_ok  = fwd_valid && (fwd_prio < pmask) && (fwd_prio < run_prio) && !full;
    cand_src = (fwd_id < SGI_LIM) ? fwd_src : '0;
  end
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active #(
  parameter int ID_W   = 10,
  parameter int SRC_W  = 3,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [SRC_W-1:0]  push_src,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              eoi_try,
  input  logic [ID_W-1:0]   eoi_id,
  input  logic [SRC_W-1:0]  eoi_src,
  output logic              eoi_hit,
  output logic              full,
  output logic [PRIO_W-1:0] run_prio
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [SRC_W-1:0]  src_q  [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [ID_W-1:0]   id_d   [DEPTH];
  logic [SRC_W-1:0]  src_d  [DEPTH];
  logic [PRIO_W-1:0] prio_d [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DEPTH-1:0]  hit_vec;
  logic [IDX_W-1:0]  hit_idx;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_match
      assign hit_vec[g] = (CNT_W'(g) < cnt_q) && (id_q[g] == eoi_id) && (src_q[g] == eoi_src);
    end
  endgenerate

  always_comb begin
    hit_idx  = '0;
    run_prio = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (CNT_W'(i + 1) == cnt_q) run_prio = prio_q[i];
    end
    full    = (cnt_q == CNT_W'(DEPTH));
    eoi_hit = eoi_try && (|hit_vec);
  end

  always_comb begin
    cnt_d = cnt_q;
    for (int i = 0; i < DEPTH; i++) begin
      id_d[i]   = id_q[i];
      src_d[i]  = src_q[i];
      prio_d[i] = prio_q[i];
    end
    if (eoi_hit) begin
      cnt_d = cnt_q - 1'b1;
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= hit_idx) begin
          id_d[i]   = id_q[i+1];
          src_d[i]  = src_q[i+1];
          prio_d[i] = prio_q[i+1];
        end
      end
    end else if (push && !full) begin
      cnt_d = cnt_q + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == cnt_q) begin
          id_d[i]   = push_id;
          src_d[i]  = push_src;
          prio_d[i] = push_prio;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        id_q[i]   <= '0;
        src_q[i]  <= '0;
        prio_q[i] <= '0;
      end
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) begin
        id_q[i]   <= id_d[i];
        src_q[i]  <= src_d[i];
        prio_q[i] <= prio_d[i];
      end
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R11
  AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !eoi_hit) |=> (cnt_q == CNT_W'(DEPTH))); // R11
endmodule

// File: rtl/cpu_intf_ack.sv
module cpu_intf_ack #(
  parameter int ID_W    = 10,
  parameter int SRC_W   = 3,
  parameter int PRIO_W  = 8,
  parameter int DEPTH   = 4,
  parameter int DATA_W  = 32,
  parameter int SGI_NUM = 16,
  parameter int MAX_ID  = 510
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fwd_valid,
  input  logic [ID_W-1:0]   fwd_id,
  input  logic [SRC_W-1:0]  fwd_src,
  input  logic [PRIO_W-1:0] fwd_prio,
  output logic              ack_req,
  output logic [ID_W-1:0]   ack_id,
  output logic [SRC_W-1:0]  ack_src,
  output logic              eoi_req,
  output logic [ID_W-1:0]   eoi_id,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              irq_out
);
  import cpuif_pkg::*;

  localparam int ACKV_W = ID_W + SRC_W;
  localparam logic [ID_W-1:0] SPURIOUS = '1;

  logic              en_q, en_d;
  logic [PRIO_W-1:0] pmask_q, pmask_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ackv_q, ackv_d;
  logic [ID_W-1:0]   ackid_q, ackid_d;
  logic [SRC_W-1:0]  acksrc_q, acksrc_d;
  logic              eoiv_q, eoiv_d;
  logic [ID_W-1:0]   eoiid_q, eoiid_d;
  logic [SRC_W-1:0]  eoisrc_q, eoisrc_d;
  logic              irq_q, irq_d;

  logic              cand_ok, full, eoi_hit, take;
  logic [SRC_W-1:0]  cand_src;
  logic [PRIO_W-1:0] run_prio;
  logic              rd_ack, wr_eoi;
  logic [ACKV_W-1:0] ack_val;
  logic [ID_W-1:0]   wr_id;
  logic [SRC_W-1:0]  wr_src;

  assign rd_ack = reg_rd && (reg_addr == RA_ACK);
  assign wr_eoi = reg_wr && (reg_addr == RA_EOI);
  assign wr_id  = reg_wdata[ID_W-1:0];
  assign wr_src = reg_wdata[ACKV_W-1:ID_W];

  cpuif_gate #(.ID_W(ID_W), .SRC_W(SRC_W), .PRIO_W(PRIO_W), .SGI_NUM(SGI_NUM)) i_gate (
    .fwd_valid (fwd_valid),
    .fwd_id    (fwd_id),
    .fwd_src   (fwd_src),
    .fwd_prio  (fwd_prio),
    .pmask     (pmask_q),
    .run_prio  (run_prio),
    .full      (full),
    .cand_ok   (cand_ok),
    .cand_src  (cand_src)
  );

  assign take = rd_ack && en_q && cand_ok && !eoi_hit;

  cpuif_active #(.ID_W(ID_W), .SRC_W(SRC_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) i_active (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (take),
    .push_id   (fwd_id),
    .push_src  (cand_src),
    .push_prio (fwd_prio),
    .eoi_try   (wr_eoi),
    .eoi_id    (wr_id),
    .eoi_src   (wr_src),
    .eoi_hit   (eoi_hit),
    .full      (full),
    .run_prio  (run_prio)
  );

  always_comb begin
    ack_val  = take ? {cand_src, fwd_id} : {{SRC_W{1'b0}}, SPURIOUS};
    en_d     = en_q;
    pmask_d  = pmask_q;
    if (reg_wr && (reg_addr == RA_CTRL))  en_d    = reg_wdata[0];
    if (reg_wr && (reg_addr == RA_PMASK)) pmask_d = reg_wdata[PRIO_W-1:0];
    rdata_d = rdata_q;
    if (reg_rd) begin
      case (reg_addr)
        RA_CTRL:  rdata_d = DATA_W'(en_q);
        RA_PMASK: rdata_d = DATA_W'(pmask_q);
        RA_ACK:   rdata_d = DATA_W'(ack_val);
        default:  rdata_d = '0;
      endcase
    end
    ackv_d   = take;
    ackid_d  = take ? fwd_id : ackid_q;
    acksrc_d = take ? cand_src : acksrc_q;
    eoiv_d   = eoi_hit;
    eoiid_d  = eoi_hit ? wr_id : eoiid_q;
    eoisrc_d = eoi_hit ? wr_src : eoisrc_q;
    irq_d    = en_q && cand_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pmask_q  <= '0;
      rdata_q  <= '0;
      ackv_q   <= 1'b0;
      ackid_q  <= '0;
      acksrc_q <= '0;
      eoiv_q   <= 1'b0;
      eoiid_q  <= '0;
      eoisrc_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      en_q     <= en_d;
      pmask_q  <= pmask_d;
      rdata_q  <= rdata_d;
      ackv_q   <= ackv_d;
      ackid_q  <= ackid_d;
      acksrc_q <= acksrc_d;
      eoiv_q   <= eoiv_d;
      eoiid_q  <= eoiid_d;
      eoisrc_q <= eoisrc_d;
      irq_q    <= irq_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign ack_req   = ackv_q;
  assign ack_id    = ackid_q;
  assign ack_src   = acksrc_q;
  assign eoi_req   = eoiv_q;
  assign eoi_id    = eoiid_q;
  assign eoi_src   = eoisrc_q;
  assign irq_out   = irq_q;

  AST_FWD_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_id <= ID_W'(MAX_ID))); // R4
  AST_ACK_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(reg_rd && (reg_addr == RA_ACK))); // R5
  AST_ACK_MATCHES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (reg_rdata[ACKV_W-1:0] == {ack_src, ack_id})); // R5
  AST_ACK_NOT_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (ack_id != SPURIOUS)); // R6
  AST_EOI_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_req |-> $past(reg_wr && (reg_addr == RA_EOI))); // R8
  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_CTRL) && !reg_wdata[0]) |=> ##1 !irq_out); // R2
endmodule

// File: tb/test_cpu_intf_ack.sv
module test_cpu_intf_ack;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_rd, reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        fwd_valid;
  logic [9:0]  fwd_id;
  logic [2:0]  fwd_src;
  logic [7:0]  fwd_prio;
  logic        ack_req, eoi_req, irq_out;
  logic [9:0]  ack_id, eoi_id;
  logic [2:0]  ack_src, eoi_src;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] rv;
  logic        rack;

  always #5 clk = ~clk;

  cpu_intf_ack i_cpu_intf_ack (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fwd_valid(fwd_valid), .fwd_id(fwd_id),
    .fwd_src(fwd_src), .fwd_prio(fwd_prio), .ack_req(ack_req), .ack_id(ack_id),
    .ack_src(ack_src), .eoi_req(eoi_req), .eoi_id(eoi_id), .eoi_src(eoi_src), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [7:0]  mask;
    logic        v;
    logic [9:0]  id;
    logic [2:0]  src;
    logic [7:0]  prio;
    logic [12:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hF0, 1'b1, 10'd40,  3'd5, 8'h80, 13'd40},
    '{8'hF0, 1'b1, 10'd3,   3'd5, 8'h10, 13'd5123},
    '{8'hF0, 1'b1, 10'd50,  3'd1, 8'hF0, 13'd1023},
    '{8'hF0, 1'b0, 10'd60,  3'd0, 8'h20, 13'd1023},
    '{8'h81, 1'b1, 10'd510, 3'd0, 8'h80, 13'd510},
    '{8'hFF, 1'b1, 10'd15,  3'd7, 8'hFE, 13'd7183},
    '{8'h00, 1'b1, 10'd20,  3'd0, 8'h00, 13'd1023},
    '{8'h01, 1'b1, 10'd0,   3'd2, 8'h00, 13'd2048}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    rv = reg_rdata; rack = ack_req;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic fwd(input logic v, input logic [9:0] id, input logic [2:0] s, input logic [7:0] p);
    fwd_valid = v; fwd_id = id; fwd_src = s; fwd_prio = p;
  endtask

  task automatic ack_expect(input string req, input logic [12:0] exp);
    rd(2'd2);
    chk(rv == 32'(exp), req, rv, 32'(exp));
    chk(rack == (exp != 13'd1023), req, 32'(rack), 32'(exp != 13'd1023));
    if (exp != 13'd1023) chk({ack_src, ack_id} == exp, req, 32'({ack_src, ack_id}), 32'(exp));
    fwd_valid = 1'b0;
  endtask

  task automatic eoi_expect(input string req, input logic [12:0] val, input bit hit);
    wr(2'd3, 32'(val));
    chk(eoi_req == hit, req, 32'(eoi_req), 32'(hit));
    if (hit) chk({eoi_src, eoi_id} == val, req, 32'({eoi_src, eoi_id}), 32'(val));
  endtask

  task automatic irq_expect(input string req, input bit exp);
    @(negedge clk);
    chk(irq_out == exp, req, 32'(irq_out), 32'(exp));
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    fwd(1'b0, 10'd0, 3'd0, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq_out == 1'b0, "R1", 32'(irq_out), 0);
    rd(2'd0); chk(rv == 0, "R1", rv, 0);
    rd(2'd1); chk(rv == 0, "R1", rv, 0);
    ack_expect("R1", 13'd1023);

    // R2 disabled: qualifying candidate blocked
    wr(2'd1, 32'hF0);
    fwd(1'b1, 10'd33, 3'd0, 8'h10);
    irq_expect("R2", 1'b0);
    ack_expect("R2", 13'd1023);
    wr(2'd0, 32'h1);
    rd(2'd0); chk(rv == 1, "R2", rv, 1);

    // vector table: R3 R4 R5 R6 R8
    foreach (VECS[k]) begin
      wr(2'd1, 32'(VECS[k].mask));
      fwd(VECS[k].v, VECS[k].id, VECS[k].src, VECS[k].prio);
      irq_expect("R3", VECS[k].exp != 13'd1023);
      ack_expect("R4", VECS[k].exp);
      if (VECS[k].exp != 13'd1023) eoi_expect("R8", VECS[k].exp, 1'b1);
    end

    // R7 running priority, R9 ignored EOI, R10 out-of-order EOI
    wr(2'd1, 32'hF0);
    fwd(1'b1, 10'd40, 3'd0, 8'h80); irq_expect("R7", 1'b1); ack_expect("R7", 13'd40);
    fwd(1'b1, 10'd41, 3'd0, 8'h80); irq_expect("R7", 1'b0); ack_expect("R7", 13'd1023);
    fwd(1'b1, 10'd42, 3'd0, 8'h40); irq_expect("R7", 1'b1); ack_expect("R7", 13'd42);
    eoi_expect("R9", 13'd99, 1'b0);
    fwd(1'b1, 10'd43, 3'd0, 8'h60); irq_expect("R9", 1'b0);
    eoi_expect("R10", 13'd40, 1'b1);
    irq_expect("R10", 1'b0);
    eoi_expect("R8", 13'd42, 1'b1);
    irq_expect("R8", 1'b1);
    ack_expect("R8", 13'd43);
    eoi_expect("R8", 13'd43, 1'b1);

    // R11 depth limit
    fwd(1'b1, 10'd100, 3'd0, 8'h80); irq_expect("R11", 1'b1); ack_expect("R11", 13'd100);
    fwd(1'b1, 10'd101, 3'd0, 8'h60); irq_expect("R11", 1'b1); ack_expect("R11", 13'd101);
    fwd(1'b1, 10'd102, 3'd0, 8'h40); irq_expect("R11", 1'b1); ack_expect("R11", 13'd102);
    fwd(1'b1, 10'd5,   3'd6, 8'h20); irq_expect("R11", 1'b1); ack_expect("R11", 13'd6149);
    fwd(1'b1, 10'd104, 3'd0, 8'h10); irq_expect("R11", 1'b0); ack_expect("R11", 13'd1023);
    eoi_expect("R11", 13'd6149, 1'b1);
    eoi_expect("R11", 13'd102, 1'b1);
    eoi_expect("R11", 13'd101, 1'b1);
    eoi_expect("R11", 13'd100, 1'b1);

    // R2 disabling drops the request
    fwd(1'b1, 10'd200, 3'd0, 8'h10); irq_expect("R2", 1'b1);
    wr(2'd0, 32'h0);
    irq_expect("R2", 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule